// File: doc/BRIEF.md
# Event and List Packet Transmitter

This block builds unsolicited outgoing packets that announce an event or carry a list of 32-bit data words. A requester hands over a destination path address of up to four bytes, a payload-type byte and a fill choice in one valid/ready request. It then feeds the payload as a valid/ready stream of 32-bit words, with a last flag on the final word. The block serialises the packet byte by byte on a valid/ready output and closes it with an end-of-packet beat.

Every packet has the same layout. First come the path address bytes, with any leading zero bytes left out. Then come a fixed command byte, the payload-type byte, the payload words with the most significant byte first, optional zero fill bytes and a checksum byte. The fill count sits in command bits 6:5. When fill is enabled, three fill bytes bring payload-type plus payload plus fill to a multiple of four bytes. The checksum is the modulo-256 sum of every byte from the command byte through the last fill byte.

On both streams a beat moves on a rising clock edge where valid and ready are both high. A source that raises valid keeps it high, with its data stable, until that beat moves. The output obeys this rule on every byte. The word input is consumed only on the cycle its fourth byte leaves the block. The output may be held off by a low `ob_ready` for any number of cycles.

Top module: `evt_pkt_tx`

## Requirements
- R1: `req_ready` is high exactly when no packet is in progress. On acceptance, `req_addr`, `req_ptype` and `fill_en` are captured, and later changes to them have no effect on the packet. `req_ready` goes low the cycle after acceptance and returns high the cycle after the end-of-packet beat moves. While `req_ready` is high, `ob_valid` is low.
- R2: The 32-bit `req_addr` holds the address bytes with bits 31:24 first. Leading bytes equal to 0x00 are not sent. The remaining bytes are sent in order, including any zero bytes that follow a nonzero one.
- R3: If all four address bytes are zero, exactly one 0x00 address byte is sent.
- R4: The byte after the address is the command byte. It is 0x92 when fill is disabled, and 0xF2 (fill count 3 in bits 6:5) when fill is enabled.
- R5: The byte after the command byte is the captured payload-type byte.
- R6: Each payload word is sent as four bytes, bits 31:24 first. `wd_ready` is high only while the fourth byte of a word is being accepted at the output. The payload ends after the word marked `wd_last`.
- R7: With fill enabled, exactly three 0x00 bytes follow the payload. With fill disabled, none are sent.
- R8: The checksum byte after the payload (and fill, if any) equals the modulo-256 sum of the command, payload-type, payload and fill bytes. Address bytes are not included.
- R9: The final beat of every packet has `ob_eop` high and `ob_data` equal to 0x00, and it directly follows the checksum byte.
- R10: While `ob_valid` is high and `ob_ready` is low, the next cycle keeps `ob_valid` high with `ob_data` and `ob_eop` unchanged.
- R11: During and right after reset, `req_ready` is high, and `ob_valid` and `wd_ready` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Packet request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | 32 | Path address bytes, bits 31:24 first |
| req_ptype | input | 8 | Payload-type byte |
| fill_en | input | 1 | Pad the payload with three fill bytes |
| wd_valid | input | 1 | Payload word offered |
| wd_ready | output | 1 | Payload word consumed this cycle |
| wd_data | input | 32 | Payload word |
| wd_last | input | 1 | Marks the final payload word |
| ob_valid | output | 1 | Output byte or end-of-packet offered |
| ob_ready | input | 1 | Downstream takes the output beat |
| ob_data | output | 8 | Output byte (0x00 on end-of-packet) |
| ob_eop | output | 1 | Beat is the end-of-packet marker |

## Verification
The assertions assume that the word source follows the stream rule: once `wd_valid` is high, it stays high with `wd_data` and `wd_last` stable until `wd_ready` takes the word. The output hold check depends on this, because payload bytes are taken directly from the offered word. They also assume that every packet carries at least one word. The bench's word producer inserts idle gaps only before it raises valid, never while a word waits. Every packet it sends has one or more words, and it changes the request fields only after acceptance, to show that they are ignored from then on.

// File: rtl/evt_pkt_pkg.sv
package evt_pkt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_CMD, ST_PTYPE, ST_PAY, ST_FILL, ST_CSUM, ST_EOP
  } tx_state_e;

  localparam int          WORD_BYTES = 4;
  localparam int          FILL_BYTES = WORD_BYTES - 1;
  localparam logic [7:0]  CMD_BASE   = 8'h92;
  localparam logic [7:0]  CMD_PADDED = CMD_BASE | 8'(FILL_BYTES << 5);
endpackage

// File: rtl/evt_addr_trim.sv
module evt_addr_trim #(
  parameter int ADDR_BYTES = 4,
  localparam int AIW = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1
) (
  input  logic [8*ADDR_BYTES-1:0] addr,
  output logic [AIW-1:0]          first_idx
);
  // Byte index 0 is the most significant byte; the last byte is always sent.
  always_comb begin
    first_idx = AIW'(ADDR_BYTES - 1);
    for (int i = ADDR_BYTES - 2; i >= 0; i--) begin
      if (addr[8*(ADDR_BYTES-1-i) +: 8] != 8'h00) first_idx = AIW'(i);
    end
  end
endmodule

// File: rtl/evt_csum_acc.sv
module evt_csum_acc (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       add_en,
  input  logic [7:0] din,
  output logic [7:0] sum
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sum <= 8'h00;
    else if (clr)    sum <= 8'h00;
    else if (add_en) sum <= sum + din;
  end
endmodule

// File: rtl/evt_pkt_seq.sv
module evt_pkt_seq
  import evt_pkt_pkg::*;
#(
  parameter int ADDR_BYTES = 4,
  localparam int AW  = 8 * ADDR_BYTES,
  localparam int WW  = 8 * WORD_BYTES,
  localparam int AIW = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1,
  localparam int CW  = $clog2(WORD_BYTES)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [AW-1:0]  req_addr,
  input  logic [7:0]     req_ptype,
  input  logic           fill_en,
  input  logic [AIW-1:0] first_idx,
  input  logic           wd_valid,
  output logic           wd_ready,
  input  logic [WW-1:0]  wd_data,
  input  logic           wd_last,
  output logic           ob_valid,
  input  logic           ob_ready,
  output logic [7:0]     ob_data,
  output logic           ob_eop,
  input  logic [7:0]     csum,
  output logic           csum_clr,
  output logic           csum_add
);
  tx_state_e      state;
  logic [AW-1:0]  addr_q;
  logic [7:0]     ptype_q;
  logic           fill_q;
  logic [AIW-1:0] aidx;
  logic [CW-1:0]  cnt;
  logic           beat;

  assign beat      = ob_valid && ob_ready;
  assign req_ready = (state == ST_IDLE);
  assign csum_clr  = req_valid && req_ready;
  assign csum_add  = beat && (state == ST_CMD || state == ST_PTYPE ||
                              state == ST_PAY || state == ST_FILL);

  always_comb begin
    ob_valid = 1'b0;
    ob_data  = 8'h00;
    ob_eop   = 1'b0;
    wd_ready = 1'b0;
    case (state)
      ST_ADDR: begin
        ob_valid = 1'b1;
        ob_data  = addr_q[8*(ADDR_BYTES-1-int'(aidx)) +: 8];
      end
      ST_CMD: begin
        ob_valid = 1'b1;
        ob_data  = fill_q ? CMD_PADDED : CMD_BASE;
      end
      ST_PTYPE: begin
        ob_valid = 1'b1;
        ob_data  = ptype_q;
      end
      ST_PAY: begin
        ob_valid = wd_valid;
        ob_data  = wd_data[8*(WORD_BYTES-1-int'(cnt)) +: 8];
        wd_ready = ob_ready && (cnt == CW'(WORD_BYTES - 1));
      end
      ST_FILL: ob_valid = 1'b1;
      ST_CSUM: begin
        ob_valid = 1'b1;
        ob_data  = csum;
      end
      ST_EOP: begin
        ob_valid = 1'b1;
        ob_eop   = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      addr_q  <= '0;
      ptype_q <= 8'h00;
      fill_q  <= 1'b0;
      aidx    <= '0;
      cnt     <= '0;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          addr_q  <= req_addr;
          ptype_q <= req_ptype;
          fill_q  <= fill_en;
          aidx    <= first_idx;
          state   <= ST_ADDR;
        end
        ST_ADDR: if (beat) begin
          if (aidx == AIW'(ADDR_BYTES - 1)) state <= ST_CMD;
          else aidx <= aidx + 1'b1;
        end
        ST_CMD:   if (beat) state <= ST_PTYPE;
        ST_PTYPE: if (beat) begin
          state <= ST_PAY;
          cnt   <= '0;
        end
        ST_PAY: if (beat) begin
          if (cnt == CW'(WORD_BYTES - 1)) begin
            cnt <= '0;
            if (wd_last) state <= fill_q ? ST_FILL : ST_CSUM;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_FILL: if (beat) begin
          if (cnt == CW'(FILL_BYTES - 1)) begin
            cnt   <= '0;
            state <= ST_CSUM;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_CSUM: if (beat) state <= ST_EOP;
        ST_EOP:  if (beat) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/evt_pkt_tx.sv
module evt_pkt_tx (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_addr,
  input  logic [7:0]  req_ptype,
  input  logic        fill_en,
  input  logic        wd_valid,
  output logic        wd_ready,
  input  logic [31:0] wd_data,
  input  logic        wd_last,
  output logic        ob_valid,
  input  logic        ob_ready,
  output logic [7:0]  ob_data,
  output logic        ob_eop
);
  localparam int ADDR_BYTES = 4;
  localparam int AIW = $clog2(ADDR_BYTES);

  logic [AIW-1:0] first_idx;
  logic [7:0]     csum;
  logic           csum_clr;
  logic           csum_add;

  evt_addr_trim #(.ADDR_BYTES(ADDR_BYTES)) u_trim (
    .addr      (req_addr),
    .first_idx (first_idx)
  );

  evt_csum_acc u_csum (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (csum_clr),
    .add_en (csum_add),
    .din    (ob_data),
    .sum    (csum)
  );

  evt_pkt_seq #(.ADDR_BYTES(ADDR_BYTES)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_ptype (req_ptype),
    .fill_en   (fill_en),
    .first_idx (first_idx),
    .wd_valid  (wd_valid),
    .wd_ready  (wd_ready),
    .wd_data   (wd_data),
    .wd_last   (wd_last),
    .ob_valid  (ob_valid),
    .ob_ready  (ob_ready),
    .ob_data   (ob_data),
    .ob_eop    (ob_eop),
    .csum      (csum),
    .csum_clr  (csum_clr),
    .csum_add  (csum_add)
  );
endmodule

// File: rtl/evt_pkt_tx_chk.sv
module evt_pkt_tx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        wd_valid,
  input logic        wd_ready,
  input logic        wd_last,
  input logic        ob_valid,
  input logic        ob_ready,
  input logic [7:0]  ob_data,
  input logic        ob_eop
);
  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ob_valid && !ob_ready) |=> (ob_valid && $stable(ob_data) && $stable(ob_eop)));

  assert_single_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_reopen_after_eop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ob_valid && ob_ready && ob_eop) |=> req_ready);

  assert_quiet_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !ob_valid);

  assert_eop_data_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ob_valid && ob_eop) |-> (ob_data == 8'h00));

  assert_word_paced_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_valid && wd_ready) |-> (ob_valid && ob_ready));
endmodule

bind evt_pkt_tx evt_pkt_tx_chk u_chk (.*);

// File: tb/test_evt_pkt_tx.sv
module test_evt_pkt_tx;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, fill_en;
  logic [31:0] req_addr;
  logic [7:0]  req_ptype;
  logic        wd_valid, wd_ready, wd_last;
  logic [31:0] wd_data;
  logic        ob_valid, ob_ready, ob_eop;
  logic [7:0]  ob_data;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  logic [7:0]  exp_b [64];
  string       exp_tag [64];
  int          exp_n;
  logic [31:0] words [8];
  logic [15:0] rng_w = 16'hACE1;
  logic [15:0] rng_o = 16'h1D2B;

  always #10 clk = ~clk;

  evt_pkt_tx i_evt_pkt_tx (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_ptype(req_ptype), .fill_en(fill_en),
    .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_data(wd_data), .wd_last(wd_last),
    .ob_valid(ob_valid), .ob_ready(ob_ready), .ob_data(ob_data), .ob_eop(ob_eop)
  );

  function automatic logic [15:0] lfsr(input logic [15:0] x);
    return {x[14:0], x[15] ^ x[13] ^ x[12] ^ x[10]};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b, input string tag);
    exp_b[exp_n]   = b;
    exp_tag[exp_n] = tag;
    exp_n++;
  endtask

  task automatic build(input logic [31:0] addr, input logic [7:0] pt,
                       input bit fill, input int n, input int id);
    int lz;
    logic [7:0] sum, cmd;
    exp_n = 0;
    lz = 0;
    while (lz < 3 && addr[8*(3-lz) +: 8] == 8'h00) lz++;
    for (int k = lz; k < 4; k++) push(addr[8*(3-k) +: 8], (addr == 0) ? "R3" : "R2");
    cmd = fill ? 8'hF2 : 8'h92;
    push(cmd, "R4");
    push(pt, "R5");
    sum = cmd + pt;
    for (int i = 0; i < n; i++) begin
      words[i] = (32'(id * 16 + i + 1)) * 32'h9E3779B1;
      for (int j = 0; j < 4; j++) begin
        push(words[i][8*(3-j) +: 8], "R6");
        sum = sum + words[i][8*(3-j) +: 8];
      end
    end
    if (fill) for (int f = 0; f < 3; f++) push(8'h00, "R7");
    push(sum, "R8");
  endtask

  task automatic produce(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wd_valid = 1'b0;
      rng_w = lfsr(rng_w);
      repeat (int'(rng_w[1:0]) % 3) @(negedge clk);
      wd_valid = 1'b1;
      wd_data  = words[i];
      wd_last  = (i == n - 1);
      forever begin
        #5;
        if (wd_ready) break;
        @(negedge clk);
      end
    end
    @(negedge clk);
    wd_valid = 1'b0;
    wd_last  = 1'b0;
  endtask

  task automatic consume(input bit stall);
    int got = 0;
    bit done = 0;
    bit prev_stall = 0;
    logic [7:0] pd = 8'h00;
    logic pe = 1'b0;
    while (!done) begin
      @(negedge clk);
      rng_o = lfsr(rng_o);
      ob_ready = stall ? rng_o[0] : 1'b1;
      #5;
      if (prev_stall)
        chk(ob_valid && ob_data == pd && ob_eop == pe, "R10 hold", int'(ob_data), int'(pd));
      prev_stall = ob_valid && !ob_ready;
      pd = ob_data;
      pe = ob_eop;
      if (ob_valid && ob_ready) begin
        if (ob_eop) begin
          chk(got == exp_n, "R9 eop position", got, exp_n);
          chk(ob_data == 8'h00, "R9 eop data", int'(ob_data), 0);
          done = 1;
        end else begin
          if (got < exp_n)
            chk(ob_data == exp_b[got], exp_tag[got], int'(ob_data), int'(exp_b[got]));
          else
            chk(1'b0, "R9 extra byte", int'(ob_data), 0);
          got++;
        end
      end
    end
    @(negedge clk);
    ob_ready = 1'b0;
    #5;
    chk(req_ready == 1'b1, "R1 ready after eop", int'(req_ready), 1);
  endtask

  task automatic run_pkt(input logic [31:0] addr, input logic [7:0] pt,
                         input bit fill, input int n, input bit stall, input int id);
    build(addr, pt, fill, n, id);
    @(negedge clk);
    req_addr  = addr;
    req_ptype = pt;
    fill_en   = fill;
    req_valid = 1'b1;
    #5;
    chk(req_ready == 1'b1, "R1 idle ready", int'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    req_addr  = ~addr;
    req_ptype = ~pt;
    fill_en   = ~fill;
    #5;
    chk(req_ready == 1'b0, "R1 busy", int'(req_ready), 0);
    fork
      produce(n);
      consume(stall);
    join
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] a;
    int id;
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_ptype = '0; fill_en = 1'b0;
    wd_valid = 1'b0; wd_data = '0; wd_last = 1'b0; ob_ready = 1'b0;
    repeat (3) @(negedge clk);
    #5;
    chk(req_ready == 1'b1, "R11 reset req_ready", int'(req_ready), 1);
    chk(ob_valid == 1'b0, "R11 reset ob_valid", int'(ob_valid), 0);
    chk(wd_ready == 1'b0, "R11 reset wd_ready", int'(wd_ready), 0);
    @(negedge clk);
    rst_n = 1'b1;
    #5;
    chk(req_ready == 1'b1 && !ob_valid, "R11 after reset", int'(ob_valid), 0);
    id = 0;
    for (int pat = 0; pat < 16; pat++) begin
      for (int f = 0; f < 2; f++) begin
        for (int k = 0; k < 4; k++)
          a[8*(3-k) +: 8] = pat[3-k] ? 8'(8'h11 * (k + 1) + pat) : 8'h00;
        run_pkt(a, 8'(pat * 16 + f), f[0], 1 + (pat % 3), (pat + f) % 2 == 1, id);
        id++;
      end
    end
    run_pkt(32'h0000_00FF, 8'hFF, 1'b1, 8, 1'b1, id);
    run_pkt(32'h0100_0000, 8'h80, 1'b0, 8, 1'b0, id + 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule